// File: doc/BRIEF.md
# Byte/Word ALU with Status Flags

This block is the integer arithmetic and logic stage of a 16-bit datapath. Each accepted operation produces a registered result one clock later. The operation can be an add, a subtract, a bitwise logic function, a one-position shift or a barrel shift. The block also returns the five status flags in their updated form, together with a mask that marks which flags the operation is allowed to change. A byte/word select sets the width that all flag arithmetic uses. In byte mode only the low eight bits are computed. The upper eight bits of the destination operand are passed through unchanged.

The surrounding pipeline supplies the current flags on `flagsIn`. Flags that an operation does not affect come back unchanged on `flagsOut`. Carry-chained add and subtract take their carry from `flagsIn`. Their Zero flag can only be cleared, never set, so a multi-word result is zero only if every word of it was zero. The caller can store `flagsOut` directly, or merge it under `flagMask` into its own status register.

Top module: `flag_alu`

## Requirements
- R1: `outValid` is high in the cycle after a cycle with `inValid` high and low otherwise. `resultOut`, `flagsOut` and `flagMask` show the registered outcome of that operation. During reset all outputs are zero.
- R2: When `byteMode`=1, `resultOut[15:8]` equals `opA[15:8]` and only bits 7:0 are computed. When `byteMode`=0, all 16 bits are computed.
- R3: The opcodes `op` are 0 ADD (A+B), 1 ADDC (A+B+C), 2 SUB (A-B), 3 SUBB (A-B-1+C) and 4 AND, 5 OR, 6 XOR. Subtraction is A + ~B + carry-in in two's complement, where the carry-in is 1 for SUB and C for SUBB and ADDC.
- R4: For add and subtract, C is the carry out of the top bit of the active width (bit 7 in byte mode, bit 15 in word mode). On subtraction C=1 means no borrow.
- R5: For add and subtract, DC is the carry out of bit 3 in byte mode and of bit 7 in word mode. On subtraction it also acts as an inverted borrow.
- R6: OV is set for signed overflow of an add or subtract at the active width. N equals the top bit of the active-width result for every operation.
- R7: Z is set when the active-width result is zero. For ADDC and SUBB the new Z is the old Z AND the zero test, so these operations can only clear it.
- R8: Logic operations update Z and N only. C, OV and DC keep their `flagsIn` values.
- R9: Opcodes 7 SHL1, 8 SHR1 (logical) and 9 SAR1 (arithmetic) shift by one position. The bit shifted out goes into C. They update C, Z and N.
- R10: Opcodes 10 SHLN, 11 SHRN and 12 SARN shift by `opB[3:0]` (0 to 15) in one cycle. SARN fills with the sign bit of the active width. Positions past the width give all-zero (or all-sign) results. These opcodes update Z and N only.
- R11: The flag bit positions in `flagsIn`, `flagsOut` and `flagMask` are 0=C, 1=Z, 2=OV, 3=N, 4=DC. Every flag whose mask bit is 0 equals its `flagsIn` value. Add and subtract use mask 5'b11111, logic ops and barrel shifts use 5'b01010, and one-bit shifts use 5'b01011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode (see R3, R9, R10) |
| byteMode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| opA | input | 16 | First operand and destination value |
| opB | input | 16 | Second operand or shift count |
| flagsIn | input | 5 | Current flags {DC,N,OV,Z,C} |
| outValid | output | 1 | Result registered this cycle |
| resultOut | output | 16 | Result |
| flagsOut | output | 5 | Updated flags {DC,N,OV,Z,C} |
| flagMask | output | 5 | Flags affected by the operation |

## Verification
Some properties are checked by the assertions on every cycle:
- the valid timing;
- the pass-through of the upper byte;
- the preservation of every unmasked flag;
- the mask used for logic operations;
- that N tracks the top bit of the active width.

Other behaviour can only be shown by the scoreboard's directed scenarios, which compare against a model built from the requirements:
- the arithmetic values themselves;
- the placement of C and DC at each width and their borrow sense;
- the sticky Z of the carry-chained operations;
- the bit shifted out by one-position shifts;
- the sign fill of barrel shifts, including counts of 0 and counts beyond the byte width.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  localparam int DATA_W = 16;
  localparam int FLAG_N = 5;

  localparam int FLG_C  = 0;
  localparam int FLG_Z  = 1;
  localparam int FLG_OV = 2;
  localparam int FLG_N  = 3;
  localparam int FLG_DC = 4;

  localparam logic [FLAG_N-1:0] MASK_ALL = 5'b11111;
  localparam logic [FLAG_N-1:0] MASK_ZN  = 5'b01010;
  localparam logic [FLAG_N-1:0] MASK_CZN = 5'b01011;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_SHL1 = 4'd7,
    OP_SHR1 = 4'd8,
    OP_SAR1 = 4'd9,
    OP_SHLN = 4'd10,
    OP_SHRN = 4'd11,
    OP_SARN = 4'd12
  } aluOp_e;

  typedef enum logic [1:0] {
    SEL_ARITH = 2'd0,
    SEL_LOGIC = 2'd1,
    SEL_SHIFT = 2'd2
  } resSel_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logicSel_e;

  typedef struct packed {
    resSel_e           resSel;
    logicSel_e         logicSel;
    logic              invB;
    logic              useCin;
    logic              stickyZ;
    logic              shLeft;
    logic              shArith;
    logic              multiBit;
    logic [FLAG_N-1:0] mask;
  } aluStrobe_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [3:0]  op,
  output aluStrobe_t  strobe
);

  always_comb begin
    strobe          = '0;
    strobe.resSel   = SEL_ARITH;
    strobe.logicSel = LG_AND;
    strobe.mask     = MASK_ALL;
    case (op)
      OP_ADD:  ;
      OP_ADDC: begin strobe.useCin = 1'b1; strobe.stickyZ = 1'b1; end
      OP_SUB:  strobe.invB = 1'b1;
      OP_SUBB: begin strobe.invB = 1'b1; strobe.useCin = 1'b1; strobe.stickyZ = 1'b1; end
      OP_AND:  begin strobe.resSel = SEL_LOGIC; strobe.logicSel = LG_AND; strobe.mask = MASK_ZN; end
      OP_OR:   begin strobe.resSel = SEL_LOGIC; strobe.logicSel = LG_OR;  strobe.mask = MASK_ZN; end
      OP_XOR:  begin strobe.resSel = SEL_LOGIC; strobe.logicSel = LG_XOR; strobe.mask = MASK_ZN; end
      OP_SHL1: begin strobe.resSel = SEL_SHIFT; strobe.shLeft = 1'b1; strobe.mask = MASK_CZN; end
      OP_SHR1: begin strobe.resSel = SEL_SHIFT; strobe.mask = MASK_CZN; end
      OP_SAR1: begin strobe.resSel = SEL_SHIFT; strobe.shArith = 1'b1; strobe.mask = MASK_CZN; end
      OP_SHLN: begin strobe.resSel = SEL_SHIFT; strobe.shLeft = 1'b1; strobe.multiBit = 1'b1; strobe.mask = MASK_ZN; end
      OP_SHRN: begin strobe.resSel = SEL_SHIFT; strobe.multiBit = 1'b1; strobe.mask = MASK_ZN; end
      OP_SARN: begin strobe.resSel = SEL_SHIFT; strobe.shArith = 1'b1; strobe.multiBit = 1'b1; strobe.mask = MASK_ZN; end
      default: strobe.mask = '0;
    endcase
  end

endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int DataW = DATA_W
) (
  input  aluStrobe_t         strobe,
  input  logic               byteMode,
  input  logic [DataW-1:0]   opA,
  input  logic [DataW-1:0]   opB,
  input  logic [FLAG_N-1:0]  flagsIn,
  output logic [DataW-1:0]   result,
  output logic [FLAG_N-1:0]  flagsNext
);

  localparam int HalfW = DataW / 2;
  localparam int QtrW  = HalfW / 2;
  localparam int ShW   = $clog2(DataW);

  logic [DataW-1:0] bOp;
  logic             carryIn;
  logic [DataW:0]   sumW;
  logic [HalfW:0]   sumLo;
  logic [QtrW:0]    sumQ;
  logic [DataW-1:0] arithRes, logicRes, shiftRes, actRes;
  logic [ShW-1:0]   amt;
  logic [HalfW-1:0] aLo;
  logic             cArith, dcArith, aMsb, bMsb, rMsb, cShift, isZero;
  logic [FLAG_N-1:0] newFlags;

  assign bOp     = strobe.invB ? ~opB : opB;
  assign carryIn = strobe.useCin ? flagsIn[FLG_C] : strobe.invB;

  assign sumW  = {1'b0, opA} + {1'b0, bOp} + {{DataW{1'b0}}, carryIn};
  assign sumLo = {1'b0, opA[HalfW-1:0]} + {1'b0, bOp[HalfW-1:0]} + {{HalfW{1'b0}}, carryIn};
  assign sumQ  = {1'b0, opA[QtrW-1:0]} + {1'b0, bOp[QtrW-1:0]} + {{QtrW{1'b0}}, carryIn};

  assign arithRes = byteMode ? {{HalfW{1'b0}}, sumLo[HalfW-1:0]} : sumW[DataW-1:0];
  assign cArith   = byteMode ? sumLo[HalfW] : sumW[DataW];
  assign dcArith  = byteMode ? sumQ[QtrW] : sumLo[HalfW];

  always_comb begin
    case (strobe.logicSel)
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = opA & opB;
    endcase
    if (byteMode) logicRes[DataW-1:HalfW] = '0;
  end

  assign amt = strobe.multiBit ? opB[ShW-1:0] : ShW'(1);
  assign aLo = opA[HalfW-1:0];

  always_comb begin
    if (byteMode) begin
      if (strobe.shLeft)       shiftRes = {{HalfW{1'b0}}, aLo << amt};
      else if (strobe.shArith) shiftRes = {{HalfW{1'b0}}, HalfW'($signed(aLo) >>> amt)};
      else                     shiftRes = {{HalfW{1'b0}}, aLo >> amt};
      cShift = strobe.shLeft ? opA[HalfW-1] : opA[0];
    end else begin
      if (strobe.shLeft)       shiftRes = opA << amt;
      else if (strobe.shArith) shiftRes = DataW'($signed(opA) >>> amt);
      else                     shiftRes = opA >> amt;
      cShift = strobe.shLeft ? opA[DataW-1] : opA[0];
    end
  end

  always_comb begin
    case (strobe.resSel)
      SEL_LOGIC: actRes = logicRes;
      SEL_SHIFT: actRes = shiftRes;
      default:   actRes = arithRes;
    endcase
  end

  assign aMsb   = byteMode ? opA[HalfW-1]    : opA[DataW-1];
  assign bMsb   = byteMode ? bOp[HalfW-1]    : bOp[DataW-1];
  assign rMsb   = byteMode ? actRes[HalfW-1] : actRes[DataW-1];
  assign isZero = byteMode ? (actRes[HalfW-1:0] == '0) : (actRes == '0);

  always_comb begin
    newFlags          = '0;
    newFlags[FLG_C]   = (strobe.resSel == SEL_SHIFT) ? cShift : cArith;
    newFlags[FLG_Z]   = isZero & (strobe.stickyZ ? flagsIn[FLG_Z] : 1'b1);
    newFlags[FLG_OV]  = (aMsb == bMsb) && (rMsb != aMsb);
    newFlags[FLG_N]   = rMsb;
    newFlags[FLG_DC]  = dcArith;
  end

  assign flagsNext = (newFlags & strobe.mask) | (flagsIn & ~strobe.mask);
  assign result    = byteMode ? {opA[DataW-1:HalfW], actRes[HalfW-1:0]} : actRes;

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [3:0]         op,
  input  logic               byteMode,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [FLAG_N-1:0]  flagsIn,
  output logic               outValid,
  output logic [DATA_W-1:0]  resultOut,
  output logic [FLAG_N-1:0]  flagsOut,
  output logic [FLAG_N-1:0]  flagMask
);

  localparam int HalfW = DATA_W / 2;

  aluStrobe_t        strobe;
  logic [DATA_W-1:0] resultNext;
  logic [FLAG_N-1:0] flagsNext;

  flag_alu_ctrl u_ctrl (
    .op     (op),
    .strobe (strobe)
  );

  flag_alu_dp #(.DataW(DATA_W)) u_dp (
    .strobe    (strobe),
    .byteMode  (byteMode),
    .opA       (opA),
    .opB       (opB),
    .flagsIn   (flagsIn),
    .result    (resultNext),
    .flagsNext (flagsNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      resultOut <= '0;
      flagsOut  <= '0;
      flagMask  <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        resultOut <= resultNext;
        flagsOut  <= flagsNext;
        flagMask  <= strobe.mask;
      end
    end
  end

  // R1: valid follows the accepted operation by one cycle
  a_r1_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(inValid)));

  // R2: byte mode keeps the destination's upper byte
  a_r2_upper_byte_kept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && byteMode) |=> (resultOut[DATA_W-1:HalfW] == $past(opA[DATA_W-1:HalfW])));

  // R11: flags outside the mask are returned unchanged
  a_r11_unmasked_flags: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (((flagsOut ^ $past(flagsIn)) & ~flagMask) == '0));

  // R8: logic operations touch only Z and N
  a_r8_logic_mask: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> (flagMask == MASK_ZN));

  // R6: N is the top bit of the active-width result
  a_r6_negative_bit: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op <= OP_SARN) |=>
      (flagsOut[FLG_N] == ($past(byteMode) ? resultOut[HalfW-1] : resultOut[DATA_W-1])));

endmodule

// File: tb/flag_alu_test.sv
module flag_alu_test;
  import flag_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  op = '0;
  logic        byteMode = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic [4:0]  flagsIn = '0;
  logic        outValid;
  logic [15:0] resultOut;
  logic [4:0]  flagsOut, flagMask;

  int testCount = 0;
  int failCount = 0;
  bit driveDone = 1'b0;

  typedef struct {
    string       tag;
    logic [15:0] res;
    logic [4:0]  flg;
    logic [4:0]  msk;
  } expItem_t;

  expItem_t scoreQ[$];

  always #2.5 clk = ~clk;

  flag_alu uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op), .byteMode(byteMode),
    .opA(opA), .opB(opB), .flagsIn(flagsIn), .outValid(outValid),
    .resultOut(resultOut), .flagsOut(flagsOut), .flagMask(flagMask)
  );

  function automatic expItem_t model(string tag, int o, bit bm, int a, int b, logic [4:0] fin);
    expItem_t e;
    int w, m, hw, hm, aa, bb, cin, sum, res, sh, sa;
    logic [4:0] nf, mk;
    w  = bm ? 8 : 16;
    m  = (1 << w) - 1;
    hw = bm ? 4 : 8;
    hm = (1 << hw) - 1;
    aa = a & m;
    nf = '0;
    res = 0;
    mk = 5'b00000;
    if (o <= 3) begin
      bb  = (o >= 2) ? ((~b) & m) : (b & m);
      cin = (o == 0) ? 0 : (o == 2) ? 1 : int'(fin[0]);
      sum = aa + bb + cin;
      res = sum & m;
      nf[0] = sum[w];
      nf[4] = (((aa & hm) + (bb & hm) + cin) >> hw) & 1;
      nf[2] = (aa[w-1] == bb[w-1]) && (res[w-1] != aa[w-1]);
      nf[1] = (res == 0) && ((o == 1 || o == 3) ? fin[1] : 1'b1);
      mk = 5'b11111;
    end else if (o <= 6) begin
      res = (o == 4) ? (aa & b) : (o == 5) ? (aa | b) : (aa ^ b);
      res = res & m;
      nf[1] = (res == 0);
      mk = 5'b01010;
    end else begin
      sh = (o >= 10) ? (b & 15) : 1;
      sa = aa[w-1] ? (aa - (1 << w)) : aa;
      if (o == 7 || o == 10) res = (aa << sh) & m;
      else if (o == 8 || o == 11) res = aa >> sh;
      else res = (sa >>> sh) & m;
      nf[0] = (o == 7) ? aa[w-1] : aa[0];
      nf[1] = (res == 0);
      mk = (o <= 9) ? 5'b01011 : 5'b01010;
    end
    nf[3] = res[w-1];
    e.tag = tag;
    e.msk = mk;
    e.flg = (nf & mk) | (fin & ~mk);
    e.res = bm ? {a[15:8], res[7:0]} : res[15:0];
    return e;
  endfunction

  task automatic drive(string tag, int o, bit bm, int a, int b, logic [4:0] fin);
    @(negedge clk);
    inValid  = 1'b1;
    op       = o[3:0];
    byteMode = bm;
    opA      = a[15:0];
    opB      = b[15:0];
    flagsIn  = fin;
    scoreQ.push_back(model(tag, o, bm, a, b, fin));
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic check(string what, int act, int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  initial begin : monitor
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (rstN && outValid) begin
        if (scoreQ.size() == 0) begin
          check("R1 unexpected outValid", 1, 0);
        end else begin
          e = scoreQ.pop_front();
          check({e.tag, " result"}, resultOut, e.res);
          check({e.tag, " flags"},  flagsOut,  e.flg);
          check({e.tag, " mask"},   flagMask,  e.msk);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!driveDone) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outValid", outValid, 0);
    check("R1 reset result", resultOut, 0);
    check("R1 reset flags", {flagsOut, flagMask}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle outValid", outValid, 0);

    drive("R3 add word",            0, 0, 16'h1234, 16'h0001, 5'b00000);
    drive("R4 add word carry/zero", 0, 0, 16'hFFFF, 16'h0001, 5'b00000);
    drive("R5 add byte digit carry",0, 1, 16'hAB0F, 16'h0001, 5'b00000);
    drive("R6 add word overflow",   0, 0, 16'h7FFF, 16'h0001, 5'b00000);
    drive("R6 add byte overflow",   0, 1, 16'h127F, 16'h0001, 5'b00000);
    drive("R4 sub no borrow",       2, 0, 16'h0005, 16'h0003, 5'b00000);
    drive("R4 sub borrow",          2, 0, 16'h0003, 16'h0005, 5'b00000);
    drive("R5 sub byte nibble borrow", 2, 1, 16'h7710, 16'h0001, 5'b00000);
    drive("R5 sub word dc",         2, 0, 16'h0100, 16'h0001, 5'b00000);
    drive("R3 addc with carry",     1, 0, 16'h0001, 16'h0001, 5'b00001);
    drive("R7 subb zero keeps Z",   3, 0, 16'h0005, 16'h0005, 5'b00011);
    drive("R7 subb zero without Z", 3, 0, 16'h0005, 16'h0005, 5'b00001);
    drive("R7 addc byte zero no Z", 1, 1, 16'h55FF, 16'h0000, 5'b00001);
    idle();
    drive("R8 and keeps C OV DC",   4, 0, 16'hF0F0, 16'h0FF0, 5'b10101);
    drive("R8 or word",             5, 0, 16'h8000, 16'h0001, 5'b00000);
    drive("R2 xor byte upper kept", 6, 1, 16'hC35A, 16'h00A5, 5'b11111);
    drive("R9 shl1 carry out",      7, 0, 16'h8001, 16'h0000, 5'b00100);
    drive("R9 shr1 byte to zero",   8, 1, 16'h9901, 16'h0000, 5'b00000);
    drive("R9 sar1 word",           9, 0, 16'h8000, 16'h0000, 5'b00001);
    drive("R9 shl1 byte top bit",   7, 1, 16'h0080, 16'h0000, 5'b00000);
    drive("R10 shln by 0",         10, 0, 16'hA5A5, 16'h0000, 5'b00001);
    drive("R10 shln by 15",        10, 0, 16'h0003, 16'h000F, 5'b00000);
    drive("R10 sarn byte by 15",   12, 1, 16'h3380, 16'h000F, 5'b00001);
    drive("R10 shrn word by 12",   11, 0, 16'hF000, 16'h000C, 5'b10101);
    drive("R10 shrn byte by 9",    11, 1, 16'h44FF, 16'h0009, 5'b00000);
    drive("R11 sarn word by 4",    12, 0, 16'h8421, 16'h0004, 5'b11111);
    idle();
    repeat (3) @(negedge clk);
    check("R1 queue drained", scoreQ.size(), 0);
    driveDone = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule